// File: doc/BRIEF.md
# Return-from-Interrupt State Restore

This unit rebuilds the 64-bit machine state register when an interrupt handler returns. It combines the saved state word and the current state word into the new state word. It also takes the resume address from the saved program counter, with the address forced to word alignment.

A second operation returns the current state word unchanged as a general-register result. All paths are combinational. Every result has its own write-enable, and the enable is high only for the operation that produces that result.

Bit positions are counted big-endian: position 0 is the most significant bit (vector index 63), and position p is vector index 63-p.

Top module: `rfi_state_restore`

## Requirements
- R1: On a restore, new state bit 51 takes saved bit 51 when current bit 3 is 1. When current bit 3 is 0, new state bit 51 keeps current bit 51.
- R2: On a restore, new state bits 29..31 keep their current value when the current field is 010 and the saved field is 000. In every other case they take the saved bits 29..31.
- R3: On a restore, new state bits 48, 58 and 59 each equal the saved bit at the same position ORed with saved bit 49. When saved bit 49 is 1, all three bits are 1.
- R4: On a restore, new state bits 0..2, 4..28, 32, 37..41, 49..50, 52..57 and 60..63 are copied from the saved state word.
- R5: On a restore, new state bits 33..36 are 0. New state bits 3 and 42..47 keep their current value.
- R6: On a restore, the next address equals the saved program counter with its two least significant bits (vector bits 1:0) forced to 0.
- R7: On a state read, the register result equals the current state word exactly.
- R8: op_i encoding is 0 = none, 1 = restore, 2 = state read, 3 = reserved.
  - A restore raises msr_we_o and nia_we_o only.
  - A state read raises gpr_we_o only.
  - Codes 0 and 3 raise no enable.
  - Each data output is zero whenever its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation select: 0 none, 1 restore, 2 state read, 3 reserved |
| msr_i | input | 64 | Current machine state word |
| srr0_i | input | 64 | Saved program counter |
| srr1_i | input | 64 | Saved machine state word |
| msr_o | output | 64 | New machine state word |
| msr_we_o | output | 1 | Write-enable for msr_o |
| nia_o | output | 64 | Next instruction address |
| nia_we_o | output | 1 | Write-enable for nia_o |
| gpr_o | output | 64 | General-register result |
| gpr_we_o | output | 1 | Write-enable for gpr_o |

## Verification
The unit contains no registers, so every result and every enable is due in the same cycle the operands are applied. The bench drives new operands just after a rising clock edge. It compares all six outputs at the following falling edge, by which point the combinational paths have settled and the next stimulus has not yet arrived. Directed cases cover each branch of the conditional merges, namely the 010/000 field case with its near misses and the hypervisor bit in both states. They also cover the problem-state override and the two idle codes.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_RESTORE  = 2'd1,
    OP_READ_MSR = 2'd2,
    OP_RSVD     = 2'd3
  } rfi_op_e;

  // big-endian bit positions
  localparam int B_HV    = 3;
  localparam int B_TS_LO = 29;
  localparam int B_TS_HI = 31;
  localparam int B_Z_LO  = 33;
  localparam int B_Z_HI  = 36;
  localparam int B_K_LO  = 42;
  localparam int B_K_HI  = 47;
  localparam int B_EE    = 48;
  localparam int B_PR    = 49;
  localparam int B_ME    = 51;
  localparam int B_IR    = 58;
  localparam int B_DR    = 59;

  function automatic int be_idx(input int pos);
    return XLEN - 1 - pos;
  endfunction
endpackage

// File: rtl/rfi_msr_merge.sv
module rfi_msr_merge
  import rfi_pkg::*;
(
  input  logic [XLEN-1:0] cur_msr_i,
  input  logic [XLEN-1:0] srr1_i,
  output logic [XLEN-1:0] new_msr_o
);
  localparam int TS_W = B_TS_HI - B_TS_LO + 1;

  logic            hv, pr, keep_ts;
  logic [TS_W-1:0] cur_ts, sav_ts;

  assign hv      = cur_msr_i[be_idx(B_HV)];
  assign pr      = srr1_i[be_idx(B_PR)];
  assign cur_ts  = cur_msr_i[be_idx(B_TS_LO) -: TS_W];
  assign sav_ts  = srr1_i[be_idx(B_TS_LO) -: TS_W];
  assign keep_ts = (cur_ts == 3'b010) && (sav_ts == 3'b000);

  for (genvar p = 0; p < XLEN; p++) begin : g_bit
    localparam int I = XLEN - 1 - p;
    if (p == B_ME) begin : g_me
      assign new_msr_o[I] = hv ? srr1_i[I] : cur_msr_i[I];
    end else if (p >= B_TS_LO && p <= B_TS_HI) begin : g_ts
      assign new_msr_o[I] = keep_ts ? cur_msr_i[I] : srr1_i[I];
    end else if (p == B_EE || p == B_IR || p == B_DR) begin : g_force
      assign new_msr_o[I] = srr1_i[I] | pr;
    end else if (p >= B_Z_LO && p <= B_Z_HI) begin : g_zero
      assign new_msr_o[I] = 1'b0;
    end else if (p == B_HV || (p >= B_K_LO && p <= B_K_HI)) begin : g_keep
      assign new_msr_o[I] = cur_msr_i[I];
    end else begin : g_copy
      assign new_msr_o[I] = srr1_i[I];
    end
  end
endmodule

// File: rtl/rfi_nia_align.sv
module rfi_nia_align #(
  parameter int W     = 64,
  parameter int ALIGN = 2
) (
  input  logic [W-1:0] pc_i,
  output logic [W-1:0] nia_o
);
  assign nia_o = {pc_i[W-1:ALIGN], {ALIGN{1'b0}}};
endmodule

// File: rtl/rfi_op_decode.sv
module rfi_op_decode
  import rfi_pkg::*;
(
  input  logic [1:0] op_i,
  output logic       restore_o,
  output logic       read_o
);
  rfi_op_e op;
  assign op = rfi_op_e'(op_i);

  always_comb begin
    restore_o = 1'b0;
    read_o    = 1'b0;
    unique case (op)
      OP_RESTORE:  restore_o = 1'b1;
      OP_READ_MSR: read_o    = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/rfi_state_restore.sv
module rfi_state_restore
  import rfi_pkg::*;
#(
  parameter int ALIGN = 2
) (
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic [XLEN-1:0] srr0_i,
  input  logic [XLEN-1:0] srr1_i,
  output logic [XLEN-1:0] msr_o,
  output logic            msr_we_o,
  output logic [XLEN-1:0] nia_o,
  output logic            nia_we_o,
  output logic [XLEN-1:0] gpr_o,
  output logic            gpr_we_o
);
  logic            restore, read;
  logic [XLEN-1:0] merged, aligned;

  rfi_op_decode i_dec (
    .op_i     (op_i),
    .restore_o(restore),
    .read_o   (read)
  );

  rfi_msr_merge i_merge (
    .cur_msr_i(msr_i),
    .srr1_i   (srr1_i),
    .new_msr_o(merged)
  );

  rfi_nia_align #(.W(XLEN), .ALIGN(ALIGN)) i_align (
    .pc_i (srr0_i),
    .nia_o(aligned)
  );

  assign msr_we_o = restore;
  assign nia_we_o = restore;
  assign gpr_we_o = read;
  assign msr_o    = restore ? merged  : '0;
  assign nia_o    = restore ? aligned : '0;
  assign gpr_o    = read    ? msr_i   : '0;
endmodule

// File: rtl/rfi_state_restore_chk.sv
module rfi_state_restore_chk (
  input logic [1:0]  op_i,
  input logic [63:0] msr_i,
  input logic [63:0] srr0_i,
  input logic [63:0] srr1_i,
  input logic [63:0] msr_o,
  input logic        msr_we_o,
  input logic [63:0] nia_o,
  input logic        nia_we_o,
  input logic [63:0] gpr_o,
  input logic        gpr_we_o
);
  // big-endian p -> index 63-p
  always_comb begin
    if (msr_we_o) begin
      p_me_rule_r1: assert (msr_o[12] == (msr_i[60] ? srr1_i[12] : msr_i[12]));
      p_ts_rule_r2: assert (msr_o[34:32] ==
        (((msr_i[34:32] == 3'b010) && (srr1_i[34:32] == 3'b000)) ? msr_i[34:32] : srr1_i[34:32]));
      if (srr1_i[14]) begin
        p_pr_force_r3: assert (msr_o[15] && msr_o[5] && msr_o[4]);
      end
      p_copy_r4: assert (msr_o[63:61] == srr1_i[63:61] && msr_o[59:35] == srr1_i[59:35] &&
                         msr_o[31] == srr1_i[31] && msr_o[26:22] == srr1_i[26:22] &&
                         msr_o[14:13] == srr1_i[14:13] && msr_o[11:6] == srr1_i[11:6] &&
                         msr_o[3:0] == srr1_i[3:0]);
      p_zero_keep_r5: assert (msr_o[30:27] == 4'b0 && msr_o[60] == msr_i[60] &&
                              msr_o[21:16] == msr_i[21:16]);
    end
    if (nia_we_o) begin
      p_align_r6: assert (nia_o == {srr0_i[63:2], 2'b00});
    end
    if (gpr_we_o) begin
      p_read_r7: assert (gpr_o == msr_i);
    end
    p_we_excl_r8: assert ($countones({msr_we_o | nia_we_o, gpr_we_o}) <= 1);
    p_we_idle_r8: assert (!((op_i == 2'd0 || op_i == 2'd3) && (msr_we_o || nia_we_o || gpr_we_o)));
    p_we_pair_r8: assert (msr_we_o == nia_we_o);
  end
endmodule

bind rfi_state_restore rfi_state_restore_chk i_chk (.*);

// File: tb/test_rfi_state_restore.sv
module test_rfi_state_restore;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [63:0] msr_i = '0, srr0_i = '0, srr1_i = '0;
  logic [63:0] msr_o, nia_o, gpr_o;
  logic        msr_we_o, nia_we_o, gpr_we_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rfi_state_restore i_rfi_state_restore (.*);

  function automatic logic [63:0] exp_msr(input logic [63:0] m, input logic [63:0] s);
    logic [63:0] r;
    logic keep_ts;
    keep_ts = (m[63-29] == 1'b0) && (m[63-30] == 1'b1) && (m[63-31] == 1'b0) &&
              (s[63-29] == 1'b0) && (s[63-30] == 1'b0) && (s[63-31] == 1'b0);
    for (int p = 0; p < 64; p++) begin
      if (p == 51)                          r[63-p] = m[63-3] ? s[63-p] : m[63-p]; // R1
      else if (p >= 29 && p <= 31)          r[63-p] = keep_ts ? m[63-p] : s[63-p]; // R2
      else if (p == 48 || p == 58 || p == 59) r[63-p] = s[63-p] | s[63-49];        // R3
      else if (p >= 33 && p <= 36)          r[63-p] = 1'b0;                        // R5
      else if (p == 3 || (p >= 42 && p <= 47)) r[63-p] = m[63-p];                  // R5
      else                                  r[63-p] = s[63-p];                     // R4
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (op=%0d msr=%h srr0=%h srr1=%h)",
               req, act, exp, op_i, msr_i, srr0_i, srr1_i);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [63:0] m,
                       input logic [63:0] s0, input logic [63:0] s1, input string tag);
    logic r, rd;
    @(posedge clk); #1;
    op_i = op; msr_i = m; srr0_i = s0; srr1_i = s1;
    @(negedge clk);
    r  = (op == 2'd1);
    rd = (op == 2'd2);
    chk({tag, " R8 msr_we"}, {63'b0, msr_we_o}, {63'b0, r});
    chk({tag, " R8 nia_we"}, {63'b0, nia_we_o}, {63'b0, r});
    chk({tag, " R8 gpr_we"}, {63'b0, gpr_we_o}, {63'b0, rd});
    chk({tag, " R1-msr R2 R3 R4 R5"}, msr_o, r ? exp_msr(m, s1) : 64'h0);
    chk({tag, " R6 nia"}, nia_o, r ? {s0[63:2], 2'b00} : 64'h0);
    chk({tag, " R7 gpr"}, gpr_o, rd ? m : 64'h0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] m, s1;
    void'($urandom(32'h5eed_1234));
    #20 rst_ni = 1'b1;
    // reset state: idle op, all enables low (R8)
    @(negedge clk);
    chk("reset R8", {61'b0, msr_we_o, nia_we_o, gpr_we_o}, 64'h0);

    // R2: 010 / 000 keeps current field
    m  = 64'h0; m[63-30] = 1'b1; m[63-29] = 1'b0; m[63-31] = 1'b0;
    s1 = 64'hFFFF_FFF8_FFFF_FFFF; s1[63-29] = 0; s1[63-30] = 0; s1[63-31] = 0;
    apply(2'd1, m, 64'h1234_5678_9ABC_DEF3, s1, "dir keep_ts");
    chk("R2 keep", {61'b0, msr_o[34:32]}, 64'd2);
    // R2 near misses
    apply(2'd1, m, 64'h3, s1 | (64'h1 << 32), "dir ts_sav001");
    chk("R2 take", {61'b0, msr_o[34:32]}, 64'd1);
    apply(2'd1, m | (64'h1 << 34), 64'h2, s1, "dir ts_cur110");
    chk("R2 take zero", {61'b0, msr_o[34:32]}, 64'd0);
    // R1: hv set/clear
    apply(2'd1, 64'h1000_0000_0000_0000, 64'h0, 64'h0000_0000_0000_1000, "dir hv1");
    chk("R1 hv=1", {63'b0, msr_o[12]}, 64'd1);
    apply(2'd1, 64'h0000_0000_0000_0000, 64'h0, 64'h0000_0000_0000_1000, "dir hv0");
    chk("R1 hv=0", {63'b0, msr_o[12]}, 64'd0);
    // R3: problem state forces EE/IR/DR
    apply(2'd1, 64'h0, 64'h0, 64'h0000_0000_0000_4000, "dir pr");
    chk("R3 force", {61'b0, msr_o[15], msr_o[5], msr_o[4]}, 64'd7);
    // R5: bits 33..36 cleared even when saved set
    apply(2'd1, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "dir zero");
    chk("R5 zero", {60'b0, msr_o[30:27]}, 64'd0);
    // R7 and idle codes (R8)
    apply(2'd2, 64'hDEAD_BEEF_0123_4567, 64'hFFFF, 64'hFFFF, "dir read");
    apply(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 64'hFFFF, "dir none");
    apply(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 64'hFFFF, "dir rsvd");

    for (int n = 0; n < 400; n++) begin
      m  = {$urandom, $urandom};
      s1 = {$urandom, $urandom};
      if (($urandom % 4) == 0) begin
        m[34:32]  = 3'b010;
        s1[34:32] = ($urandom % 2) ? 3'b000 : 3'($urandom);
      end
      apply(2'($urandom), m, {$urandom, $urandom}, s1, "rnd");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule